// File: doc/BRIEF.md
# Dual-Port Memory with Same-Address Arbitration

This block is a synchronous memory with two identical access ports, left and right. Each port can read or write any word on every clock. Read data comes back one clock later. If a word is written on one port while the other port reads it, the reading port sees the old contents first and the new contents on the next read.

When both ports are enabled and present the same address, an arbiter picks one port. The port that was already holding that address keeps it. The other port has busy raised toward it, and any write it attempts while busy is high is discarded. A blocked write is not queued, so the requester holds its write until busy drops. Reads on the losing port still complete normally.

A mode strap turns off the arbiter. In slave mode the busy outputs stay low and each port's busy input, driven by an external master device, is used only to discard that port's writes.

Top module: `dpram_arb`

## Requirements
- R1: A port with enable and write enable high, and not blocked, stores its write data at its address at the clock edge.
- R2: Read data appears on a port one clock after that port is enabled with an address. While the port's enable is low, its read data holds its previous value. After reset both read data outputs are 0.
- R3: When one port writes a word that the other port reads in the same cycle, the reader first gets the old contents. It gets the new contents on a read one cycle later.
- R4: In master mode (mode strap = 1), a port that comes to an address the other port already held on the previous cycle, with both enables high, sees its busy output high in that same cycle. The earlier port's busy stays low. The decision holds while both ports stay on that address, and it applies the same way with the roles swapped.
- R5: In master mode, if both ports start a same-address access in the same cycle, the left port wins and the right busy output goes high.
- R6: A write on a port whose busy is active is discarded: the memory word keeps its old contents.
- R7: In master mode, a busy output is low in any cycle where the addresses differ or either enable is low. A port whose busy has cleared can then write.
- R8: Reads on the losing port are not blocked and return the stored word one cycle later.
- R9: In slave mode (mode strap = 0), both busy outputs are low and same-address accesses are not arbitrated. If both ports write one word in the same cycle, the left port's data is kept.
- R10: In slave mode, a high busy input on a port discards that port's writes. A low busy input lets them through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | 1 = internal arbiter drives busy, 0 = busy comes from the inputs |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write enable |
| l_addr | input | ADDR_W | Left port address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data, one cycle latency |
| l_busy_in | input | 1 | External busy for the left port (slave mode) |
| l_busy_out | output | 1 | Busy toward the left port (master mode) |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write enable |
| r_addr | input | ADDR_W | Right port address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data, one cycle latency |
| r_busy_in | input | 1 | External busy for the right port (slave mode) |
| r_busy_out | output | 1 | Busy toward the right port (master mode) |

## Verification
The stimulus covers these cases:
- Writes and reads on disjoint addresses, to confirm plain storage and the one-cycle read latency.
- A write on one port against a read of the same word on the other, to separate read-old from read-new timing.
- Collisions where the left port arrives first, where the right port arrives first, and where both arrive together. These show that first-come ordering and the left tie-break are not mixed up.
- The winner leaving the address, to show that busy releases and the held write then lands.
- Slave-mode runs where two simultaneous writes hit one word and a busy input is toggled. These show that the arbiter is really off and that only the busy inputs gate writes.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_t;
endpackage

// File: rtl/dpram_arb_track.sv
// Per-port tracker: flags an access that continues on the same address
module dpram_arb_track #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              held
);
  logic              prev_en;
  logic [ADDR_W-1:0] prev_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_en   <= 1'b0;
      prev_addr <= '0;
    end else begin
      prev_en   <= en;
      prev_addr <= addr;
    end
  end

  assign held = en && prev_en && (addr == prev_addr);
endmodule

// File: rtl/dpram_arb_arbiter.sv
module dpram_arb_arbiter
  import dpram_arb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_en,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              l_busy_in,
  input  logic              r_busy_in,
  output logic              l_busy,
  output logic              r_busy,
  output logic              l_block,
  output logic              r_block
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]        en_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v;
  logic [NPORT-1:0]        held_v;
  owner_t                  owner_q;
  owner_t                  winner;
  logic                    collide;

  assign en_v   = {r_en, l_en};
  assign addr_v = {r_addr, l_addr};

  for (genvar p = 0; p < NPORT; p++) begin : g_track
    dpram_arb_track #(.ADDR_W(ADDR_W)) u_track (
      .clk  (clk),
      .rst  (rst),
      .en   (en_v[p]),
      .addr (addr_v[p]),
      .held (held_v[p])
    );
  end

  assign collide = master_mode && l_en && r_en && (l_addr == r_addr);

  always_comb begin
    if (!collide)
      winner = OWN_NONE;
    else if (owner_q != OWN_NONE && held_v[0] && held_v[1])
      winner = owner_q;
    else if (held_v[1] && !held_v[0])
      winner = OWN_RIGHT;
    else
      winner = OWN_LEFT;
  end

  always_ff @(posedge clk) begin
    if (rst) owner_q <= OWN_NONE;
    else     owner_q <= winner;
  end

  assign l_busy  = (winner == OWN_RIGHT);
  assign r_busy  = (winner == OWN_LEFT);
  assign l_block = master_mode ? l_busy : l_busy_in;
  assign r_block = master_mode ? r_busy : r_busy_in;
endmodule

// File: rtl/dpram_arb_mem.sv
// Two-port storage, read-first on both ports, written for block RAM inference
module dpram_arb_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (b_en && b_we) store[b_addr] <= b_wdata;
    if (a_en && a_we) store[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_en) a_rdata <= store[a_addr];
      if (b_en) b_rdata <= store[b_addr];
    end
  end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              l_en,
  input  logic              l_we,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              l_busy_in,
  output logic              l_busy_out,
  input  logic              r_en,
  input  logic              r_we,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic              r_busy_in,
  output logic              r_busy_out
);
  logic l_block, r_block;

  dpram_arb_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk         (clk),
    .rst         (rst),
    .master_mode (master_mode),
    .l_en        (l_en),
    .l_addr      (l_addr),
    .r_en        (r_en),
    .r_addr      (r_addr),
    .l_busy_in   (l_busy_in),
    .r_busy_in   (r_busy_in),
    .l_busy      (l_busy_out),
    .r_busy      (r_busy_out),
    .l_block     (l_block),
    .r_block     (r_block)
  );

  dpram_arb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .a_en    (l_en),
    .a_we    (l_we && !l_block),
    .a_addr  (l_addr),
    .a_wdata (l_wdata),
    .a_rdata (l_rdata),
    .b_en    (r_en),
    .b_we    (r_we && !r_block),
    .b_addr  (r_addr),
    .b_wdata (r_wdata),
    .b_rdata (r_rdata)
  );
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              master_mode,
  input logic              l_en,
  input logic [ADDR_W-1:0] l_addr,
  input logic [DATA_W-1:0] l_rdata,
  input logic              l_busy_out,
  input logic              r_en,
  input logic [ADDR_W-1:0] r_addr,
  input logic [DATA_W-1:0] r_rdata,
  input logic              r_busy_out
);
  logic same;
  assign same = l_en && r_en && (l_addr == r_addr);

  assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !master_mode |-> (!l_busy_out && !r_busy_out));

  assert_busy_needs_match_R7: assert property (@(posedge clk) disable iff (rst)
    (l_busy_out || r_busy_out) |-> same);

  assert_single_loser_R4: assert property (@(posedge clk) disable iff (rst)
    !(l_busy_out && r_busy_out));

  assert_owner_holds_R4: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(master_mode) && same && $past(same)
     && l_addr == $past(l_addr) && $past(r_busy_out)) |-> r_busy_out);

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(l_en) && !$past(r_en)) |->
      ($stable(l_rdata) && $stable(r_rdata)));
endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .master_mode (master_mode),
  .l_en        (l_en),
  .l_addr      (l_addr),
  .l_rdata     (l_rdata),
  .l_busy_out  (l_busy_out),
  .r_en        (r_en),
  .r_addr      (r_addr),
  .r_rdata     (r_rdata),
  .r_busy_out  (r_busy_out)
);

// File: tb/test_dpram_arb.sv
module test_dpram_arb;
  localparam int AW = 10;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_mode = 1'b1;
  logic l_en = 0, l_we = 0, l_busy_in = 0;
  logic r_en = 0, r_we = 0, r_busy_in = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_out, r_busy_out;

  always #2 clk = ~clk;

  dpram_arb #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_arb (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_busy_in(l_busy_in), .l_busy_out(l_busy_out),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .r_rdata(r_rdata), .r_busy_in(r_busy_in), .r_busy_out(r_busy_out)
  );

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int  m_mem [DEPTH];
  bit  m_ok  [DEPTH];
  int  m_lr = 0, m_rr = 0;
  bit  m_lok = 1, m_rok = 1;
  bit  m_plen = 0, m_pren = 0;
  int  m_pla = 0, m_pra = 0;
  int  m_owner = 0;            // 0 none, 1 left, 2 right

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit le, input bit lw, input int la, input int ld,
                     input bit re, input bit rw, input int ra, input int rd,
                     input bit lbi, input bit rbi, input string tag);
    bit coll, cl, cr, lb, rb, lblk, rblk;
    int win;
    l_en = le; l_we = lw; l_addr = AW'(la); l_wdata = DW'(ld);
    r_en = re; r_we = rw; r_addr = AW'(ra); r_wdata = DW'(rd);
    l_busy_in = lbi; r_busy_in = rbi;
    #1;
    coll = master_mode && le && re && (la == ra);
    cl = le && m_plen && (la == m_pla);
    cr = re && m_pren && (ra == m_pra);
    if (!coll) win = 0;
    else if (m_owner != 0 && cl && cr) win = m_owner;
    else if (cr && !cl) win = 2;
    else win = 1;
    lb = (win == 2);
    rb = (win == 1);
    check({tag, " l_busy"}, int'(l_busy_out), int'(lb));
    check({tag, " r_busy"}, int'(r_busy_out), int'(rb));
    lblk = master_mode ? lb : lbi;
    rblk = master_mode ? rb : rbi;
    @(posedge clk);
    if (le) begin m_lr = m_mem[la]; m_lok = m_ok[la]; end
    if (re) begin m_rr = m_mem[ra]; m_rok = m_ok[ra]; end
    if (re && rw && !rblk) begin m_mem[ra] = rd; m_ok[ra] = 1; end
    if (le && lw && !lblk) begin m_mem[la] = ld; m_ok[la] = 1; end
    m_plen = le; m_pla = la; m_pren = re; m_pra = ra; m_owner = win;
    @(negedge clk);
    if (m_lok) check({tag, " l_rdata"}, int'(l_rdata), m_lr);
    if (m_rok) check({tag, " r_rdata"}, int'(r_rdata), m_rr);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state
    check("R2 reset l_rdata", int'(l_rdata), 0);
    check("R2 reset r_rdata", int'(r_rdata), 0);
    check("R7 reset l_busy", int'(l_busy_out), 0);
    check("R7 reset r_busy", int'(r_busy_out), 0);

    // R1/R2: plain writes on both ports, cross reads
    for (int i = 0; i < 4; i++)
      cyc(1, 1, 5 + i, 16 * i + 3, 1, 1, 100 + i, 200 + i, 0, 0, "R1 write");
    for (int i = 0; i < 4; i++)
      cyc(1, 0, 100 + i, 0, 1, 0, 5 + i, 0, 0, 0, "R2 read");
    // R2: disabled port with write enable high writes nothing, rdata holds
    cyc(0, 1, 5, 77, 0, 1, 100, 88, 0, 0, "R2 disabled");
    cyc(1, 0, 5, 0, 1, 0, 100, 0, 0, 0, "R2 after disabled");

    // R3: left writes word 6 while right reads it for three cycles
    cyc(1, 1, 6, 170, 1, 0, 6, 0, 0, 0, "R3 rw same cycle");
    cyc(0, 0, 0, 0, 1, 0, 6, 0, 0, 0, "R3 new data");
    cyc(0, 0, 0, 0, 1, 0, 6, 0, 0, 0, "R3 steady");

    // R4/R6/R8: left holds 30, right arrives writing
    cyc(1, 1, 30, 240, 0, 0, 0, 0, 0, 0, "R1 preload");
    cyc(1, 0, 30, 0, 0, 0, 0, 0, 0, 0, "R4 left first");
    cyc(1, 0, 30, 0, 1, 1, 30, 85, 0, 0, "R4 right late busy");
    cyc(1, 0, 30, 0, 1, 1, 30, 85, 0, 0, "R6 right write dropped");
    cyc(1, 0, 31, 0, 1, 1, 30, 85, 0, 0, "R7 release write lands");
    cyc(0, 0, 0, 0, 1, 0, 30, 0, 0, 0, "R7 readback");

    // R4 swapped: right holds 40, left arrives writing
    cyc(0, 0, 0, 0, 1, 1, 40, 11, 0, 0, "R1 preload");
    cyc(1, 1, 40, 99, 1, 0, 40, 0, 0, 0, "R4 left late busy");
    cyc(1, 1, 40, 99, 1, 0, 40, 0, 0, 0, "R8 loser read");
    cyc(1, 0, 40, 0, 0, 0, 0, 0, 0, 0, "R6 readback");

    // R5: simultaneous start, both write word 50
    idle("R7 idle");
    cyc(1, 1, 50, 300, 1, 1, 50, 400, 0, 0, "R5 tie left wins");
    cyc(1, 0, 50, 0, 1, 0, 50, 0, 0, 0, "R5 readback");
    cyc(1, 0, 51, 0, 1, 0, 50, 0, 0, 0, "R8 reads ok");

    // R9/R10: slave mode
    master_mode = 0;
    cyc(1, 1, 60, 123, 1, 1, 60, 321, 0, 0, "R9 no arbitration");
    cyc(1, 0, 60, 0, 1, 0, 60, 0, 0, 0, "R9 readback");
    cyc(1, 1, 61, 50, 0, 0, 0, 0, 0, 0, "R1 preload slave");
    cyc(1, 1, 61, 60, 1, 1, 62, 70, 1, 0, "R10 left blocked");
    cyc(1, 0, 61, 0, 1, 0, 62, 0, 0, 0, "R10 readback");
    cyc(1, 1, 61, 65, 1, 1, 62, 75, 0, 1, "R10 right blocked");
    cyc(1, 0, 61, 0, 1, 0, 62, 0, 0, 0, "R10 readback2");
    master_mode = 1;
    idle("R7 idle end");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule